// File: doc/BRIEF.md
# Pixel Overlap Collision Register

This block watches the composed pixel stream of a display engine and records which kinds of objects overlapped on any pixel during a frame. For every valid pixel it receives eight sprite opacity flags and six bitplane data bits. The sprites form four fixed pairs, called groups 0 to 3. Group g holds sprites 2g and 2g+1. The even sprite of each pair always takes part. The odd sprite is ORed in only when its enable bit is set.

The bitplanes are not tested for being non-zero. Each one can be enabled for matching and given a polarity. The odd planes (1, 3, 5) together give one "odd hit". The even planes (2, 4, 6) together give one "even hit". This grouping depends only on the plane number and never on how the playfields are displayed.

Every overlap between an odd hit, an even hit and the sprite groups sets a sticky bit in a status register. Software reads the register once per frame, and the read clears it. A write-only control word selects the odd-sprite enables, the plane enables and the plane match values.

Top module: `pix_collide_top`

## Requirements
- R1: After reset the status register reads 0 and the control word is 0, so every plane is disabled.
- R2: A status bit is set only in a cycle where `pixValid` is 1 and its overlap condition holds. Once set, the bit stays 1 until a read.
- R3: `rdData` shows the accumulated status in the cycle `rdStrobe` is 1. After that clock edge the status is 0, unless a hit occurs in the same cycle.
- R4: A hit that occurs in the same cycle as a read is absent from that read's data and present in the next read.
- R5: Control bits 12, 13, 14 and 15 OR sprites 1, 3, 5 and 7 into groups 0, 1, 2 and 3. When the bit is 0, the odd sprite has no effect. Sprites 0, 2, 4 and 6 always count.
- R6: Control bit 6+p enables plane p+1 (p = 0..5, plane p+1 at `planeBits[p]`), and control bit p is its match value. The odd hit is true when every enabled plane among 1, 3, 5 equals its match value. The even hit is the same for planes 2, 4, 6.
- R7: If no plane of a set is enabled, that set's hit is always true. With all six planes disabled, every valid pixel sets bit 0.
- R8: Status bit 0 is odd hit AND even hit. Bits 1 to 4 are odd hit AND group 0 to 3. Bits 5 to 8 are even hit AND group 0 to 3.
- R9: Bits 9 to 14 are the group pairs 0-1, 0-2, 0-3, 1-2, 1-3 and 2-3, in that order. Bit 15 always reads 0.
- R10: A control write with `ctrlWe` takes effect from the next cycle on. A pixel in the same cycle as the write is judged with the old control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlData | input | 16 | Control word value |
| rdStrobe | input | 1 | Status read; clears the status after this edge |
| rdData | output | 16 | Current status register, bit 15 zero |
| pixValid | input | 1 | Pixel inputs are valid this cycle |
| spriteOn | input | 8 | Opacity flag of sprites 0..7 |
| planeBits | input | 6 | Data bits of bitplanes 1..6 |

## Verification
Several rules are checked on every cycle by the assertions. Status bits never drop without a read, and the status does not move when there is neither a read nor a valid pixel. A read with no hit leaves zero, and a read that coincides with a hit leaves exactly that hit. A control write lands on the next cycle, and disabled planes always give bit 0 a hit.

Only the bench scenarios can show the rest. These are the meaning of each status bit, the polarity matching on each plane set, the odd-sprite OR, the one-cycle delay of a control write, and a hit surviving across a read.

// File: rtl/collide_pkg.sv
package collide_pkg;
  localparam int SPRITE_COUNT = 8;
  localparam int PLANE_COUNT  = 6;
  localparam int GROUP_COUNT  = SPRITE_COUNT / 2;
  localparam int PAIR_COUNT   = GROUP_COUNT * (GROUP_COUNT - 1) / 2;
  localparam int LOW_COUNT    = 1 + 2 * GROUP_COUNT;
  localparam int STAT_USED    = LOW_COUNT + PAIR_COUNT;
  localparam int BUS_W        = 16;
  localparam int PLANE_EN_LSB = PLANE_COUNT;
  localparam int ODD_EN_LSB   = 2 * PLANE_COUNT;
  localparam int CTRL_USED    = ODD_EN_LSB + GROUP_COUNT;

  typedef struct packed {
    logic clearStat;
    logic sampleHit;
  } statStrobe_t;

  function automatic int pairOffset(input int a, input int b);
    return (a * (2 * GROUP_COUNT - a - 1)) / 2 + (b - a - 1);
  endfunction
endpackage

// File: rtl/collide_ctrl.sv
module collide_ctrl
  import collide_pkg::*;
#(
  parameter int CTRL_W = CTRL_USED
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              rdStrobe,
  input  logic              pixValid,
  output logic [CTRL_W-1:0] ctrlQ,
  output statStrobe_t       strb
);
  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWe) ctrlQ <= ctrlData;
  end

  always_comb begin
    strb.clearStat = rdStrobe;
    strb.sampleHit = pixValid;
  end

  // R10: a written control word is in place on the next cycle
  assert_ctrl_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> ctrlQ == $past(ctrlData));
endmodule

// File: rtl/collide_match.sv
module collide_match
  import collide_pkg::*;
#(
  parameter int GROUPS = GROUP_COUNT,
  parameter int PLANES = PLANE_COUNT,
  localparam int SPRITES = 2 * GROUPS,
  localparam int PAIRS   = GROUPS * (GROUPS - 1) / 2,
  localparam int LOWS    = 1 + 2 * GROUPS,
  localparam int EN_LSB  = PLANES,
  localparam int ODD_LSB = 2 * PLANES,
  localparam int CW      = ODD_LSB + GROUPS
) (
  input  logic [CW-1:0]         ctrlQ,
  input  logic [SPRITES-1:0]    spriteOn,
  input  logic [PLANES-1:0]     planeBits,
  output logic [LOWS+PAIRS-1:0] hitVec
);
  logic [GROUPS-1:0] grp;
  logic [PLANES-1:0] planeOk;
  logic [LOWS-1:0]   lowVec;
  logic [PAIRS-1:0]  pairVec;
  logic              oddHit;
  logic              evenHit;

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    assign grp[g] = spriteOn[2*g] | (ctrlQ[ODD_LSB+g] & spriteOn[2*g+1]);
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign planeOk[p] = ~ctrlQ[EN_LSB+p] | (planeBits[p] == ctrlQ[p]);
  end

  always_comb begin
    oddHit  = 1'b1;
    evenHit = 1'b1;
    for (int p = 0; p < PLANES; p += 2) oddHit = oddHit & planeOk[p];
    for (int p = 1; p < PLANES; p += 2) evenHit = evenHit & planeOk[p];
    lowVec[0] = oddHit & evenHit;
    for (int g = 0; g < GROUPS; g++) begin
      lowVec[1+g]        = oddHit & grp[g];
      lowVec[1+GROUPS+g] = evenHit & grp[g];
    end
  end

  for (genvar a = 0; a < GROUPS; a++) begin : g_pa
    for (genvar b = a + 1; b < GROUPS; b++) begin : g_pb
      localparam int IDX = (a * (2 * GROUPS - a - 1)) / 2 + (b - a - 1);
      assign pairVec[IDX] = grp[a] & grp[b];
    end
  end

  assign hitVec = {pairVec, lowVec};

  // R7: with no plane enabled the plane sets always collide with each other
  always_comb begin
    if (ctrlQ[EN_LSB +: PLANES] == '0)
      assert_all_off_R7: assert (hitVec[0] == 1'b1);
  end
endmodule

// File: rtl/collide_status.sv
module collide_status
  import collide_pkg::*;
#(
  parameter int STAT_W = STAT_USED
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strb,
  input  logic [STAT_W-1:0] hitVec,
  output logic [STAT_W-1:0] statusQ
);
  logic [STAT_W-1:0] keepVec;
  logic [STAT_W-1:0] newVec;

  always_comb begin
    keepVec = strb.clearStat ? '0 : statusQ;
    newVec  = strb.sampleHit ? hitVec : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else statusQ <= keepVec | newVec;
  end

  // R2: without a read, no set bit drops
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearStat |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
  // R2: no valid pixel and no read leaves the status untouched
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearStat && !strb.sampleHit) |=> $stable(statusQ));
  // R3: a read with no valid pixel empties the status
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearStat && !strb.sampleHit) |=> statusQ == '0);
  // R4: a hit in the read cycle is exactly what remains
  assert_keep_on_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearStat && strb.sampleHit) |=> statusQ == $past(hitVec));
endmodule

// File: rtl/pix_collide_top.sv
module pix_collide_top
  import collide_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlWe,
  input  logic [BUS_W-1:0]        ctrlData,
  input  logic                    rdStrobe,
  output logic [BUS_W-1:0]        rdData,
  input  logic                    pixValid,
  input  logic [SPRITE_COUNT-1:0] spriteOn,
  input  logic [PLANE_COUNT-1:0]  planeBits
);
  logic [CTRL_USED-1:0] ctrlQ;
  logic [STAT_USED-1:0] hitVec;
  logic [STAT_USED-1:0] statusQ;
  statStrobe_t          strb;

  collide_ctrl #(.CTRL_W(CTRL_USED)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData[CTRL_USED-1:0]),
    .rdStrobe(rdStrobe), .pixValid(pixValid), .ctrlQ(ctrlQ), .strb(strb)
  );

  collide_match #(.GROUPS(GROUP_COUNT), .PLANES(PLANE_COUNT)) u_match (
    .ctrlQ(ctrlQ), .spriteOn(spriteOn), .planeBits(planeBits), .hitVec(hitVec)
  );

  collide_status #(.STAT_W(STAT_USED)) u_status (
    .clk(clk), .rstN(rstN), .strb(strb), .hitVec(hitVec), .statusQ(statusQ)
  );

  assign rdData = {{(BUS_W-STAT_USED){1'b0}}, statusQ};
endmodule

// File: tb/pix_collide_top_tb.sv
module pix_collide_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [15:0] ctrlData = '0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdData;
  logic        pixValid = 1'b0;
  logic [7:0]  spriteOn = '0;
  logic [5:0]  planeBits = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_collide_top u_dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .rdStrobe(rdStrobe), .rdData(rdData), .pixValid(pixValid),
    .spriteOn(spriteOn), .planeBits(planeBits)
  );

  // {control, sprites, planes, expected status}
  localparam logic [45:0] VECS [0:NVEC-1] = '{
    {16'h0000, 8'h00, 6'h00, 16'h0001},  // R7 all planes off
    {16'h0000, 8'h01, 6'h00, 16'h0023},  // R8 sprite 0 vs both sets
    {16'h0000, 8'h02, 6'h00, 16'h0001},  // R5 sprite 1 not enabled
    {16'h1000, 8'h02, 6'h00, 16'h0023},  // R5 sprite 1 enabled
    {16'h0041, 8'h04, 6'h00, 16'h0040},  // R6 plane 1 mismatch
    {16'h0041, 8'h04, 6'h01, 16'h0045},  // R6 plane 1 match
    {16'h00C3, 8'h55, 6'h00, 16'h7E00},  // R9 all group pairs
    {16'h00C3, 8'h11, 6'h00, 16'h0400},  // R9 pair 0-2
    {16'h00C3, 8'h50, 6'h00, 16'h4000},  // R9 pair 2-3
    {16'h80C3, 8'h90, 6'h00, 16'h4000},  // R5 sprite 7 enabled
    {16'h00C3, 8'h90, 6'h00, 16'h0000},  // R5 sprite 7 ignored
    {16'h0080, 8'h40, 6'h02, 16'h0010},  // R6 even mismatch, polarity 0
    {16'h0080, 8'h40, 6'h00, 16'h0111},  // R8 group 3 vs both sets
    {16'h0304, 8'h00, 6'h37, 16'h0001},  // R6 planes 3,4 matched
    {16'h0FEA, 8'h08, 6'h2A, 16'h0001},  // R6 all planes matched
    {16'h0FEA, 8'h00, 6'h2B, 16'h0000}   // R6 plane 1 off polarity
  };

  function automatic string vecReq(input int i);
    case (i)
      0: return "R7";
      1, 12: return "R8";
      2, 3, 9, 10: return "R5";
      6, 7, 8: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input logic [15:0] exp, input string req);
    checks++;
    if (rdData !== exp || rdData[15] !== 1'b0) begin
      fails++;
      $display("FAIL %s: rdData=%04h expected=%04h", req, rdData, exp);
    end
  endtask

  task automatic writeCtrl(input logic [15:0] val);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlData = val;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic pixel(input logic [7:0] spr, input logic [5:0] pl);
    @(negedge clk);
    pixValid = 1'b1; spriteOn = spr; planeBits = pl;
    @(negedge clk);
    pixValid = 1'b0; spriteOn = '0; planeBits = '0;
  endtask

  task automatic readCheck(input logic [15:0] exp, input string req);
    @(negedge clk);
    rdStrobe = 1'b1;
    #1 check(exp, req);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung (R1..R10 incomplete)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty status after reset
    readCheck(16'h0000, "R1");
    // R1: control resets to zero, so planes are off and bit 0 sets
    pixel(8'h00, 6'h00);
    readCheck(16'h0001, "R1");

    for (int i = 0; i < NVEC; i++) begin
      writeCtrl(VECS[i][45:30]);
      pixel(VECS[i][29:22], VECS[i][21:16]);
      readCheck(VECS[i][15:0], vecReq(i));
    end

    // R2: sprites present but pixValid low
    @(negedge clk);
    spriteOn = 8'h55;
    @(negedge clk);
    spriteOn = '0;
    readCheck(16'h0000, "R2");

    // R2: accumulation of two pixels; R3: second read is empty
    writeCtrl(16'h00C3);
    pixel(8'h11, 6'h00);
    pixel(8'h50, 6'h00);
    readCheck(16'h4400, "R2");
    readCheck(16'h0000, "R3");

    // R4: hit during the read cycle survives to the next read
    pixel(8'h05, 6'h00);
    @(negedge clk);
    rdStrobe = 1'b1; pixValid = 1'b1; spriteOn = 8'h41;
    #1 check(16'h0200, "R3");
    @(negedge clk);
    rdStrobe = 1'b0; pixValid = 1'b0; spriteOn = '0;
    readCheck(16'h0800, "R4");

    // R10: pixel in the write cycle uses the old control word
    @(negedge clk);
    ctrlWe = 1'b1; ctrlData = 16'h0000; pixValid = 1'b1;
    @(negedge clk);
    ctrlWe = 1'b0; pixValid = 1'b0;
    readCheck(16'h0000, "R10");
    pixel(8'h00, 6'h00);
    readCheck(16'h0001, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule